// File: doc/BRIEF.md
# Fuse Bank Write-Protect Gate

This block sits in front of the programming strobe of a one-time fuse bank of 172 bits, organised as 32-bit words (five full words plus a sixth word with 12 implemented bits). A requester presents a blow request as a word index and a bit index. The gate reads the current fuse state and decides whether the request may reach the programming strobe. The decision depends on write-protect bits that are themselves fuses in the bank.

The protect bits form two groups. The system group covers words 0 to 4, which hold the 128-bit authentication key and the first part of the user data. The user group is word 5. A group counts as locked only when every protect bit in it is blown. A single stray blown protect bit therefore cannot lock the part by accident. The user group locks on its own, so user fuses can still be programmed after the system area is sealed.

Every request gets an acknowledge in the following cycle. With that acknowledge comes either a one-cycle blow strobe carrying the linear bit address, or a one-cycle error pulse.

Top module: `fuse_wp_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ack`, `blow_stb` and `err` are low and `blow_addr` is 0.
- R2: A request sampled on a rising edge raises `ack` for exactly the following cycle. In that cycle exactly one of `blow_stb` and `err` is high. None of the three is high in a cycle that follows no request.
- R3: The linear bit address is word index × 32 + bit index. When `blow_stb` is high, `blow_addr` carries the address of the request that caused it.
- R4: A request whose linear address is 172 or higher is rejected with `err`. This covers word 5 with bit index 12 to 31, and word indices 6 and 7.
- R5: The system protect bits are fuse indices 31, 63, 95, 127 and 159 (the top bit of words 0 to 4). When all five are blown, every request to words 0 to 4 is rejected with `err`.
- R6: When at least one of the five system protect bits is unblown, an in-range request to words 0 to 4 is accepted with `blow_stb`.
- R7: The user protect bit is fuse index 171 (bit 11 of word 5, its top implemented bit). When it is blown, in-range requests to word 5 are rejected. When it is unblown, they are accepted, whatever the state of the system group. The user bit has no effect on words 0 to 4.
- R8: A protect bit may itself be blown while its group is unlocked. For example, word 4 bit 31 is accepted while other system protect bits are still unblown, and fuse 171 is accepted while the user group is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_state | input | 172 | Sensed fuse state, bit i = linear fuse i, 1 = blown |
| req_valid | input | 1 | Blow request present this cycle |
| req_word | input | 3 | Word index of the request |
| req_bit | input | 5 | Bit index within the word |
| ack | output | 1 | Request acknowledged, one cycle after it was presented |
| blow_stb | output | 1 | One-cycle programming strobe for an accepted request |
| blow_addr | output | 8 | Linear fuse address to program |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The state inside the gate is one cycle deep, so any fault shows at the ports in the cycle after the request that exposes it. A wrong lock evaluation turns a strobe into an error, or an error into a strobe. This is most visible with exactly four of five system protect bits blown, and with the user bit blown while the system group is open. A wrong address decode or range limit shows as a wrong `blow_addr`, or as a strobe at addresses 172 and above. The check at address 171 against 172 targets the off-by-one case.

// File: rtl/fuse_gate_pkg.sv
package fuse_gate_pkg;
  typedef enum logic [1:0] {
    GRP_SYS  = 2'd0,
    GRP_USER = 2'd1
  } fuse_grp_e;
endpackage

// File: rtl/fuse_addr_decode.sv
module fuse_addr_decode
  import fuse_gate_pkg::*;
#(
  parameter int FUSE_BITS = 172,
  parameter int WORD_W    = 32,
  parameter int SYS_WORDS = 5,
  localparam int NUM_WORDS = (FUSE_BITS + WORD_W - 1) / WORD_W,
  localparam int WIDX_W    = $clog2(NUM_WORDS),
  localparam int BIDX_W    = $clog2(WORD_W),
  localparam int ADDR_W    = WIDX_W + BIDX_W
) (
  input  logic [WIDX_W-1:0] word_idx,
  input  logic [BIDX_W-1:0] bit_idx,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              in_range,
  output fuse_grp_e         grp
);
  always_comb begin
    lin_addr = {word_idx, bit_idx};
    in_range = (lin_addr < ADDR_W'(FUSE_BITS));
    grp      = (word_idx < WIDX_W'(SYS_WORDS)) ? GRP_SYS : GRP_USER;
  end
endmodule

// File: rtl/fuse_lock_eval.sv
module fuse_lock_eval #(
  parameter int FUSE_BITS = 172,
  parameter int WORD_W    = 32,
  parameter int SYS_WORDS = 5,
  localparam int NUM_WORDS = (FUSE_BITS + WORD_W - 1) / WORD_W
) (
  input  logic [FUSE_BITS-1:0] fuse_state,
  output logic                 sys_locked,
  output logic                 user_locked
);
  logic [NUM_WORDS-1:0] prot;

  // protect bit of a word: its highest implemented fuse
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_prot
    localparam int TOP = ((w + 1) * WORD_W - 1 < FUSE_BITS) ?
                         (w + 1) * WORD_W - 1 : FUSE_BITS - 1;
    assign prot[w] = fuse_state[TOP];
  end

  always_comb begin
    sys_locked  = &prot[SYS_WORDS-1:0];
    user_locked = &prot[NUM_WORDS-1:SYS_WORDS];
  end

  logic unused_fuse_xor;
  assign unused_fuse_xor = ^fuse_state;
endmodule

// File: rtl/fuse_wp_gate.sv
module fuse_wp_gate
  import fuse_gate_pkg::*;
#(
  parameter int FUSE_BITS = 172,
  parameter int WORD_W    = 32,
  parameter int SYS_WORDS = 5,
  localparam int NUM_WORDS = (FUSE_BITS + WORD_W - 1) / WORD_W,
  localparam int WIDX_W    = $clog2(NUM_WORDS),
  localparam int BIDX_W    = $clog2(WORD_W),
  localparam int ADDR_W    = WIDX_W + BIDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FUSE_BITS-1:0] fuse_state,
  input  logic                 req_valid,
  input  logic [WIDX_W-1:0]    req_word,
  input  logic [BIDX_W-1:0]    req_bit,
  output logic                 ack,
  output logic                 blow_stb,
  output logic [ADDR_W-1:0]    blow_addr,
  output logic                 err
);
  logic [ADDR_W-1:0] lin_addr;
  logic              in_range;
  fuse_grp_e         grp;
  logic              sys_locked, user_locked;
  logic              grp_locked, accept;
  logic              ack_d, stb_d, err_d;

  fuse_addr_decode #(.FUSE_BITS(FUSE_BITS), .WORD_W(WORD_W), .SYS_WORDS(SYS_WORDS)) u_dec (
    .word_idx (req_word),
    .bit_idx  (req_bit),
    .lin_addr (lin_addr),
    .in_range (in_range),
    .grp      (grp)
  );

  fuse_lock_eval #(.FUSE_BITS(FUSE_BITS), .WORD_W(WORD_W), .SYS_WORDS(SYS_WORDS)) u_lock (
    .fuse_state  (fuse_state),
    .sys_locked  (sys_locked),
    .user_locked (user_locked)
  );

  always_comb begin
    grp_locked = (grp == GRP_SYS) ? sys_locked : user_locked;
    accept     = req_valid && in_range && !grp_locked;
    ack_d      = req_valid;
    stb_d      = accept;
    err_d      = req_valid && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      blow_stb <= 1'b0;
      err      <= 1'b0;
    end else begin
      ack      <= ack_d;
      blow_stb <= stb_d;
      err      <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blow_addr <= '0;
    end else if (accept) begin
      blow_addr <= lin_addr;
    end
  end
endmodule

// File: rtl/fuse_wp_gate_chk.sv
module fuse_wp_gate_chk #(
  parameter int FUSE_BITS = 172,
  parameter int WORD_W    = 32,
  parameter int SYS_WORDS = 5,
  localparam int NUM_WORDS = (FUSE_BITS + WORD_W - 1) / WORD_W,
  localparam int WIDX_W    = $clog2(NUM_WORDS),
  localparam int BIDX_W    = $clog2(WORD_W),
  localparam int ADDR_W    = WIDX_W + BIDX_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [FUSE_BITS-1:0] fuse_state,
  input logic                 req_valid,
  input logic [WIDX_W-1:0]    req_word,
  input logic [BIDX_W-1:0]    req_bit,
  input logic                 ack,
  input logic                 blow_stb,
  input logic [ADDR_W-1:0]    blow_addr,
  input logic                 err
);
  logic all_sys_blown;
  logic [ADDR_W-1:0] req_lin;

  always_comb begin
    all_sys_blown = 1'b1;
    for (int w = 0; w < SYS_WORDS; w++)
      all_sys_blown = all_sys_blown & fuse_state[w * WORD_W + WORD_W - 1];
    req_lin = {req_word, req_bit};
  end

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ack);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req_valid));
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($countones({blow_stb, err}) == 1));
  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (!blow_stb && !err));
  // R3
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blow_stb |-> (blow_addr == $past(req_lin)));
  // R4
  range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lin >= ADDR_W'(FUSE_BITS)) |=> err);
  // R5
  sys_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word < WIDX_W'(SYS_WORDS) && all_sys_blown) |=> err);
  // R7
  user_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word >= WIDX_W'(SYS_WORDS) && fuse_state[FUSE_BITS-1]) |=> err);
endmodule

bind fuse_wp_gate fuse_wp_gate_chk #(
  .FUSE_BITS(FUSE_BITS), .WORD_W(WORD_W), .SYS_WORDS(SYS_WORDS)
) u_chk (.*);

// File: tb/fuse_wp_gate_tb.sv
`timescale 1ns/1ps
module fuse_wp_gate_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [171:0] fuse_state;
  logic         req_valid;
  logic [2:0]   req_word;
  logic [4:0]   req_bit;
  logic         ack, blow_stb, err;
  logic [7:0]   blow_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fuse_wp_gate u_dut (
    .clk(clk), .rst_n(rst_n), .fuse_state(fuse_state), .req_valid(req_valid),
    .req_word(req_word), .req_bit(req_bit), .ack(ack), .blow_stb(blow_stb),
    .blow_addr(blow_addr), .err(err)
  );

  function automatic bit model_accept(logic [171:0] fs, int w, int b);
    int a = w * 32 + b;
    bit lk;
    if (a >= 172) return 0;
    if (w < 5) lk = fs[31] & fs[63] & fs[95] & fs[127] & fs[159];
    else       lk = fs[171];
    return !lk;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a negedge, check at the next negedge (one register in between)
  task automatic apply(bit v, logic [171:0] fs, int w, int b, string req);
    bit acc;
    req_valid  = v;
    fuse_state = fs;
    req_word   = 3'(w);
    req_bit    = 5'(b);
    acc = model_accept(fs, w, b);
    @(negedge clk);
    check({req, " ack"}, ack, v);
    check({req, " stb"}, blow_stb, v && acc);
    check({req, " err"}, err, v && !acc);
    if (v && acc) check({req, " addr"}, blow_addr, w * 32 + b);
  endtask

  function automatic logic [171:0] sys_prot(int mask);
    logic [171:0] f = '0;
    for (int i = 0; i < 5; i++) if (mask[i]) f[i * 32 + 31] = 1'b1;
    return f;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [171:0] fs;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_word = '0; req_bit = '0; fuse_state = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 ack", ack, 0); check("R1 stb", blow_stb, 0);
    check("R1 err", err, 0); check("R1 addr", blow_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post ack", ack, 0); check("R1 post addr", blow_addr, 0);

    // R2 idle and back-to-back
    apply(0, '0, 0, 0, "R2 idle");
    apply(1, '0, 0, 0, "R3 first");
    apply(1, '0, 3, 17, "R3 mid");
    apply(0, '0, 3, 17, "R2 gap");
    // R4 range edges
    apply(1, '0, 5, 11, "R4 last");
    apply(1, '0, 5, 12, "R4 first out");
    apply(1, '0, 6, 0, "R4 word6");
    apply(1, '0, 7, 31, "R4 word7");
    // R6 four of five protect bits
    for (int k = 0; k < 5; k++) apply(1, sys_prot(5'h1F & ~(1 << k)), k, 5, "R6 partial");
    // R5 full system lock
    apply(1, sys_prot(5'h1F), 0, 0, "R5 locked w0");
    apply(1, sys_prot(5'h1F), 4, 31, "R5 locked w4");
    // R7 independence
    apply(1, sys_prot(5'h1F), 5, 3, "R7 user open");
    fs = '0; fs[171] = 1'b1;
    apply(1, fs, 5, 3, "R7 user locked");
    apply(1, fs, 1, 9, "R7 sys unaffected");
    // R8 protect bits themselves
    apply(1, sys_prot(5'h0F), 4, 31, "R8 sys prot");
    apply(1, sys_prot(5'h1F), 5, 11, "R8 user prot");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      for (int j = 0; j < 6; j++) fs[j * 32 +: 32] = (j == 5) ? {20'h0, 12'($urandom)} : $urandom;
      if ($urandom_range(0, 1)) fs |= sys_prot(5'h1F);
      else if ($urandom_range(0, 1)) fs |= sys_prot(int'($urandom_range(0, 31)));
      if ($urandom_range(0, 2) == 0) fs[171] = 1'b1;
      apply($urandom_range(0, 7) != 0, fs,
            $urandom_range(0, 3) == 0 ? 5 : int'($urandom_range(0, 7)),
            int'($urandom_range(0, 31)), "R2-R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule